// File: doc/BRIEF.md
# PWM Timer Compare Output Unit

A 16-bit counter with two compare channels, A and B, each driving one output pin. A 4-bit waveform-mode input chooses how the counter runs (up only and wrapping, or up then down), where its ceiling (TOP) comes from, and what kind of waveform the pins produce. The choices are free-running counting, clear-on-compare (CTC), single-slope fast PWM, and two dual-slope PWM kinds: phase correct, and phase and frequency correct. BOTTOM is always 0.

Each channel has a 2-bit output-mode field that decides how its pin reacts to a compare match, to BOTTOM and to the counting direction. The pin is a register that changes only on an enabled clock edge. It acts on the counter value held before that edge. A pin-enable flag per channel tells the surrounding port logic whether the timer owns the pin. In the PWM kinds the compare values are double-buffered, so a new duty cycle takes effect only at a clean point in the period.

Top module: `pwm_timer`

## Requirements
- R1: While reset is held, and after it is released, both pins are 0 and the counter starts at 0, counting up.
- R2: Waveform-mode codes select the following behaviour; every other code acts as 0.
  - 0: free-running up count to 0xFFFF.
  - 4: CTC, with TOP equal to compare A.
  - 5, 6 and 7: fast PWM, with TOP fixed at 0x00FF, 0x01FF and 0x03FF.
  - 14: fast PWM, with TOP from the TOP register.
  - 15: fast PWM, with TOP equal to compare A.
  - 8: phase and frequency correct, with TOP from the TOP register.
  - 9: phase and frequency correct, with TOP equal to compare A.
  - 10: phase correct, with TOP from the TOP register.
  - 11: phase correct, with TOP equal to compare A.
  - Single-slope counting goes from TOP back to 0 on the next enabled edge.
- R3: Output mode 00 disconnects a channel: its pin-enable is 0. In general, pin-enable is 1 exactly when the channel's effective output mode is not 00.
- R4: In fast PWM, output mode 10 clears the pin on an edge where the counter equals the compare value. It sets the pin on an edge where the counter is 0. This gives non-inverting output.
- R5: In fast PWM, output mode 11 sets the pin on a compare match and clears it at BOTTOM. This gives inverting output.
- R6: In fast PWM, output mode 01 toggles pin A on a match only in waveform modes 14 and 15; pin B is then disconnected. In modes 5 to 7 both channels are disconnected by 01.
- R7: In the dual-slope kinds, output mode 10 clears the pin on a match while the count is heading up and sets it on a match while heading down; mode 11 does the reverse. A match at 0 counts as heading up, and a match at TOP counts as heading down.
- R8: In the dual-slope kinds, output mode 01 toggles pin A on a match only in waveform modes 9 and 11. Otherwise both channels are disconnected by 01.
- R9: With output mode 10 or 11 in a PWM kind, a compare value equal to TOP produces no match action. Instead, at BOTTOM the pin is set for 10 and cleared for 11.
- R10: In the dual-slope kinds the counter turns from up to down on reaching TOP and from down to up on reaching 0. A period is therefore 2×TOP edges.
- R11: In PWM kinds, the compare values in use are buffers. They load on the edge that leaves TOP in fast PWM and in phase correct mode, and on the edge that leaves 0 in phase and frequency correct mode. In modes 0 and 4, and whenever counting is disabled, the compare inputs act at once.
- R12: While the count enable is 0, the counter and both pins hold their values.
- R13: In modes 0 and 4, output mode 01 toggles, 10 clears and 11 sets the pin on a compare match, on both channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count enable; edges with it low change nothing |
| wave_mode | input | 4 | Waveform mode code (R2) |
| om_a | input | 2 | Output mode of channel A |
| om_b | input | 2 | Output mode of channel B |
| cmp_a | input | 16 | Compare value A (also TOP in some modes) |
| cmp_b | input | 16 | Compare value B |
| top_reg | input | 16 | TOP register value for modes 8, 10, 14 |
| pin_a | output | 1 | Channel A pin value |
| pin_b | output | 1 | Channel B pin value |
| pin_a_en | output | 1 | Channel A owns its pin |
| pin_b_en | output | 1 | Channel B owns its pin |

## Verification
The hardest case to reach from the ports is the difference between the two dual-slope kinds. They differ only in when a changed compare value takes effect. To expose it, the stimulus changes compare A while the count is rising, before it reaches TOP. The same pin is then sampled on the falling slope. In phase correct mode the new value already acts there, while the other kind still uses the old one. Reaching the free-running wrap needs more than 65,536 enabled edges, so one scenario runs a full counter period and checks a toggle on each side of the wrap.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

  // Counting and waveform family
  typedef enum logic [1:0] {
    FAM_PLAIN = 2'd0,   // free-running or CTC, single slope, no buffering
    FAM_FAST  = 2'd1,   // single-slope PWM
    FAM_PHASE = 2'd2,   // dual slope, buffer loads at TOP
    FAM_PFREQ = 2'd3    // dual slope, buffer loads at BOTTOM
  } fam_e;

  // Where the ceiling value comes from
  typedef enum logic [1:0] {
    TOP_FULL  = 2'd0,
    TOP_FIXED = 2'd1,
    TOP_REG   = 2'd2,
    TOP_CMPA  = 2'd3
  } topsrc_e;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_SET  = 2'd1,
    ACT_CLR  = 2'd2,
    ACT_TGL  = 2'd3
  } act_e;

  typedef struct packed {
    fam_e       fam;
    topsrc_e    tsrc;
    logic [1:0] fix_sel;   // fixed TOP = 2^(8+fix_sel) - 1
    logic       a_tgl_ok;  // channel A may toggle in a PWM family
  } mode_cfg_t;

  localparam logic [1:0] OM_OFF  = 2'b00;
  localparam logic [1:0] OM_TGL  = 2'b01;
  localparam logic [1:0] OM_LOW  = 2'b10;
  localparam logic [1:0] OM_HIGH = 2'b11;

endpackage

// File: rtl/pwm_timer_decode.sv
module pwm_timer_decode
  import pwm_timer_pkg::*;
(
  input  logic [3:0] wave_mode,
  output mode_cfg_t  cfg
);

  always_comb begin
    cfg = '{fam: FAM_PLAIN, tsrc: TOP_FULL, fix_sel: 2'd0, a_tgl_ok: 1'b0};
    unique case (wave_mode)
      4'd4:  cfg = '{fam: FAM_PLAIN, tsrc: TOP_CMPA,  fix_sel: 2'd0, a_tgl_ok: 1'b0};
      4'd5:  cfg = '{fam: FAM_FAST,  tsrc: TOP_FIXED, fix_sel: 2'd0, a_tgl_ok: 1'b0};
      4'd6:  cfg = '{fam: FAM_FAST,  tsrc: TOP_FIXED, fix_sel: 2'd1, a_tgl_ok: 1'b0};
      4'd7:  cfg = '{fam: FAM_FAST,  tsrc: TOP_FIXED, fix_sel: 2'd2, a_tgl_ok: 1'b0};
      4'd8:  cfg = '{fam: FAM_PFREQ, tsrc: TOP_REG,   fix_sel: 2'd0, a_tgl_ok: 1'b0};
      4'd9:  cfg = '{fam: FAM_PFREQ, tsrc: TOP_CMPA,  fix_sel: 2'd0, a_tgl_ok: 1'b1};
      4'd10: cfg = '{fam: FAM_PHASE, tsrc: TOP_REG,   fix_sel: 2'd0, a_tgl_ok: 1'b0};
      4'd11: cfg = '{fam: FAM_PHASE, tsrc: TOP_CMPA,  fix_sel: 2'd0, a_tgl_ok: 1'b1};
      4'd14: cfg = '{fam: FAM_FAST,  tsrc: TOP_REG,   fix_sel: 2'd0, a_tgl_ok: 1'b1};
      4'd15: cfg = '{fam: FAM_FAST,  tsrc: TOP_CMPA,  fix_sel: 2'd0, a_tgl_ok: 1'b1};
      default: ;  // codes 0 and unused codes: free-running
    endcase
  end

endmodule

// File: rtl/pwm_timer_counter.sv
module pwm_timer_counter
  import pwm_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  fam_e         fam,
  input  topsrc_e      tsrc,
  input  logic [1:0]   fix_sel,
  input  logic [W-1:0] top_reg,
  input  logic [W-1:0] a_eff,
  output logic [W-1:0] count_q,
  output logic [W-1:0] top_val,
  output logic         heading_up,
  output logic         at_bottom,
  output logic         buf_load
);

  localparam int           FIX_BASE = 8;
  localparam logic [W-1:0] ONES     = '1;
  localparam logic [W-1:0] ONE      = W'(1);

  logic         dual, at_top, dir_q, dir_d;
  logic [W-1:0] cnt_d, fixed_top;

  always_comb fixed_top = ~(ONES << (FIX_BASE + int'(fix_sel)));

  always_comb begin
    unique case (tsrc)
      TOP_FULL:  top_val = ONES;
      TOP_FIXED: top_val = fixed_top;
      TOP_REG:   top_val = top_reg;
      default:   top_val = a_eff;
    endcase
  end

  assign dual      = (fam == FAM_PHASE) || (fam == FAM_PFREQ);
  assign at_top    = (count_q >= top_val);
  assign at_bottom = (count_q == '0);

  // direction the counter takes on leaving the current value
  always_comb begin
    if (!dual)          heading_up = 1'b1;
    else if (at_bottom) heading_up = 1'b1;
    else if (at_top)    heading_up = 1'b0;
    else                heading_up = dir_q;
  end

  always_comb begin
    dir_d = heading_up;
    if (!dual)                cnt_d = at_top ? '0 : count_q + ONE;
    else if (top_val == '0)   cnt_d = '0;
    else if (heading_up)      cnt_d = count_q + ONE;
    else                      cnt_d = count_q - ONE;
  end

  always_comb begin
    unique case (fam)
      FAM_FAST:  buf_load = cnt_en & at_top;
      FAM_PHASE: buf_load = cnt_en & at_top;
      FAM_PFREQ: buf_load = cnt_en & at_bottom;
      default:   buf_load = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      dir_q   <= 1'b1;
    end else if (cnt_en) begin
      count_q <= cnt_d;
      dir_q   <= dir_d;
    end
  end

endmodule

// File: rtl/pwm_timer_chan.sv
module pwm_timer_chan
  import pwm_timer_pkg::*;
#(
  parameter int W       = 16,
  parameter bit HAS_TGL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  fam_e         fam,
  input  logic         tgl_ok,
  input  logic [1:0]   om,
  input  logic [W-1:0] cmp_in,
  input  logic         buf_load,
  input  logic [W-1:0] count_q,
  input  logic [W-1:0] top_val,
  input  logic         heading_up,
  input  logic         at_bottom,
  output logic [W-1:0] cmp_eff,
  output logic         pin,
  output logic         pin_en
);

  logic [W-1:0] buf_q;
  logic         transparent, buf_upd;
  logic [1:0]   om_eff;
  logic         hit, cmp_is_top;
  act_e         act, lead, trail;
  logic         pin_q, pin_d;

  // compare buffer
  assign transparent = (fam == FAM_PLAIN) | ~cnt_en;
  assign buf_upd     = transparent | buf_load;
  assign cmp_eff     = transparent ? cmp_in : buf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       buf_q <= '0;
    else if (buf_upd) buf_q <= cmp_in;
  end

  // effective output mode
  always_comb begin
    if (om == OM_TGL)
      om_eff = ((fam == FAM_PLAIN) || (HAS_TGL && tgl_ok)) ? OM_TGL : OM_OFF;
    else
      om_eff = om;
  end
  assign pin_en = (om_eff != OM_OFF);

  assign hit        = (count_q == cmp_eff);
  assign cmp_is_top = (cmp_eff == top_val);
  assign lead       = om_eff[0] ? ACT_SET : ACT_CLR;
  assign trail      = om_eff[0] ? ACT_CLR : ACT_SET;

  always_comb begin
    act = ACT_NONE;
    if (om_eff == OM_TGL) begin
      if (hit) act = ACT_TGL;
    end else if (om_eff != OM_OFF) begin
      unique case (fam)
        FAM_PLAIN: if (hit) act = lead;
        FAM_FAST: begin
          if (hit && !cmp_is_top) act = lead;
          else if (at_bottom)     act = trail;
        end
        default: begin
          if (hit && !cmp_is_top)          act = heading_up ? lead : trail;
          else if (at_bottom && cmp_is_top) act = trail;
        end
      endcase
    end
  end

  always_comb begin
    unique case (act)
      ACT_SET: pin_d = 1'b1;
      ACT_CLR: pin_d = 1'b0;
      ACT_TGL: pin_d = ~pin_q;
      default: pin_d = pin_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pin_q <= 1'b0;
    else if (cnt_en) pin_q <= pin_d;
  end

  assign pin = pin_q;

endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import pwm_timer_pkg::*;
#(
  parameter int W         = 16,
  parameter int RST_STAGE = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic [3:0]   wave_mode,
  input  logic [1:0]   om_a,
  input  logic [1:0]   om_b,
  input  logic [W-1:0] cmp_a,
  input  logic [W-1:0] cmp_b,
  input  logic [W-1:0] top_reg,
  output logic         pin_a,
  output logic         pin_b,
  output logic         pin_a_en,
  output logic         pin_b_en
);

  localparam int NCH = 2;

  // asynchronous assert, synchronous release
  logic [RST_STAGE-1:0] rst_sr;
  logic                 rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sr <= '0;
    else        rst_sr <= {rst_sr[RST_STAGE-2:0], 1'b1};
  end
  assign rst_sync_n = rst_sr[RST_STAGE-1];

  mode_cfg_t    cfg;
  logic [W-1:0] count_q, top_val;
  logic         heading_up, at_bottom, buf_load;

  logic [NCH-1:0][W-1:0] cmp_in_v, cmp_eff_v;
  logic [NCH-1:0][1:0]   om_v;
  logic [NCH-1:0]        pin_v, en_v;

  assign cmp_in_v[0] = cmp_a;
  assign cmp_in_v[1] = cmp_b;
  assign om_v[0]     = om_a;
  assign om_v[1]     = om_b;

  pwm_timer_decode u_dec (
    .wave_mode (wave_mode),
    .cfg       (cfg)
  );

  pwm_timer_counter #(.W(W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cnt_en     (cnt_en),
    .fam        (cfg.fam),
    .tsrc       (cfg.tsrc),
    .fix_sel    (cfg.fix_sel),
    .top_reg    (top_reg),
    .a_eff      (cmp_eff_v[0]),
    .count_q    (count_q),
    .top_val    (top_val),
    .heading_up (heading_up),
    .at_bottom  (at_bottom),
    .buf_load   (buf_load)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    pwm_timer_chan #(.W(W), .HAS_TGL(ch == 0)) u_chan (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .cnt_en     (cnt_en),
      .fam        (cfg.fam),
      .tgl_ok     (cfg.a_tgl_ok),
      .om         (om_v[ch]),
      .cmp_in     (cmp_in_v[ch]),
      .buf_load   (buf_load),
      .count_q    (count_q),
      .top_val    (top_val),
      .heading_up (heading_up),
      .at_bottom  (at_bottom),
      .cmp_eff    (cmp_eff_v[ch]),
      .pin        (pin_v[ch]),
      .pin_en     (en_v[ch])
    );
  end

  assign pin_a    = pin_v[0];
  assign pin_b    = pin_v[1];
  assign pin_a_en = en_v[0];
  assign pin_b_en = en_v[1];

endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_sync_n,
  input logic         cnt_en,
  input logic [3:0]   wave_mode,
  input logic [1:0]   om_a,
  input logic [1:0]   om_b,
  input logic         pin_a,
  input logic         pin_b,
  input logic         pin_a_en,
  input logic         pin_b_en,
  input logic [W-1:0] count_q
);

  // R3
  off_a_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (om_a == 2'b00) |-> !pin_a_en);

  // R3
  off_b_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (om_b == 2'b00) |-> !pin_b_en);

  // R6
  fast_b_tgl_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((om_b == 2'b01) && (wave_mode inside {4'd5, 4'd6, 4'd7, 4'd14, 4'd15})) |-> !pin_b_en);

  // R8
  dual_b_tgl_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((om_b == 2'b01) && (wave_mode inside {4'd8, 4'd9, 4'd10, 4'd11})) |-> !pin_b_en);

  // R12
  hold_pin_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cnt_en |=> ($stable(pin_a) && $stable(pin_b)));

  // R12
  hold_cnt_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cnt_en |=> $stable(count_q));

endmodule

bind pwm_timer pwm_timer_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .cnt_en     (cnt_en),
  .wave_mode  (wave_mode),
  .om_a       (om_a),
  .om_b       (om_b),
  .pin_a      (pin_a),
  .pin_b      (pin_b),
  .pin_a_en   (pin_a_en),
  .pin_b_en   (pin_b_en),
  .count_q    (count_q)
);

// File: tb/pwm_timer_test.sv
`timescale 1ns/1ps
module pwm_timer_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cnt_en;
  logic [3:0]  wave_mode;
  logic [1:0]  om_a, om_b;
  logic [15:0] cmp_a, cmp_b, top_reg;
  logic        pin_a, pin_b, pin_a_en, pin_b_en;

  int checks = 0;
  int errors = 0;
  int edges  = 0;

  always #10 clk = ~clk;  // 50 MHz

  pwm_timer uut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wave_mode(wave_mode),
    .om_a(om_a), .om_b(om_b), .cmp_a(cmp_a), .cmp_b(cmp_b), .top_reg(top_reg),
    .pin_a(pin_a), .pin_b(pin_b), .pin_a_en(pin_a_en), .pin_b_en(pin_b_en)
  );

  task automatic chk(input logic got, input logic exp, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b (edge %0d)", what, got, exp, edges);
    end
  endtask

  task automatic setup(input logic [3:0] m, input logic [1:0] oa, input logic [1:0] ob,
                       input logic [15:0] ca, input logic [15:0] cb, input logic [15:0] tr);
    wave_mode = m; om_a = oa; om_b = ob; cmp_a = ca; cmp_b = cb; top_reg = tr;
  endtask

  task automatic reset_dut();
    cnt_en = 1'b0;
    rst_n  = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    edges  = 0;
    cnt_en = 1'b1;
  endtask

  // advance until 'upto' enabled edges have passed; ends at a falling edge
  task automatic adv(input int upto);
    while (edges < upto) begin
      @(posedge clk);
      if (cnt_en) edges++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    setup(4'd14, 2'b10, 2'b11, 16'd3, 16'd6, 16'd9);
    cnt_en = 1'b0;
    rst_n  = 1'b0;
    repeat (3) @(negedge clk);
    chk(pin_a, 1'b0, "R1 pin A in reset");
    chk(pin_b, 1'b0, "R1 pin B in reset");
    reset_dut();
    chk(pin_a, 1'b0, "R1 pin A after release");
  endtask

  task automatic t_fast_polarity();
    setup(4'd14, 2'b10, 2'b11, 16'd3, 16'd6, 16'd9);
    reset_dut();
    adv(2);  chk(pin_a, 1'b1, "R4 set at bottom");
    adv(5);  chk(pin_a, 1'b0, "R4 clear on match");
    adv(8);  chk(pin_b, 1'b1, "R5 set on match");
    adv(10); chk(pin_a, 1'b0, "R4 low until wrap");
    adv(11); chk(pin_a, 1'b1, "R2 period of TOP+1 edges");
             chk(pin_b, 1'b0, "R5 clear at bottom");
  endtask

  task automatic t_fast_top();
    setup(4'd14, 2'b10, 2'b11, 16'd9, 16'd9, 16'd9);
    reset_dut();
    adv(10); chk(pin_a, 1'b1, "R9 fast mode 10 match at TOP ignored");
             chk(pin_b, 1'b0, "R9 fast mode 11 match at TOP ignored");
    adv(11); chk(pin_a, 1'b1, "R9 pin A set at bottom");
  endtask

  task automatic t_fast_toggle();
    setup(4'd15, 2'b01, 2'b01, 16'd4, 16'd0, 16'd0);
    reset_dut();
    chk(pin_a_en, 1'b1, "R6 A toggle enabled in mode 15");
    chk(pin_b_en, 1'b0, "R6 B disconnected by 01");
    adv(5);  chk(pin_a, 1'b1, "R6 toggle at TOP match");
    adv(9);  chk(pin_a, 1'b1, "R6 hold between matches");
    adv(10); chk(pin_a, 1'b0, "R6 second toggle");
    cnt_en = 1'b0;
    wave_mode = 4'd14; #1 chk(pin_a_en, 1'b1, "R6 A toggle enabled in mode 14");
    wave_mode = 4'd5;  #1 chk(pin_a_en, 1'b0, "R6 A disconnected in mode 5");
    wave_mode = 4'd7;  #1 chk(pin_a_en, 1'b0, "R6 A disconnected in mode 7");
  endtask

  task automatic t_dual_polarity();
    setup(4'd10, 2'b10, 2'b11, 16'd2, 16'd2, 16'd5);
    reset_dut();
    adv(3);  chk(pin_a, 1'b0, "R7 mode 10 clear heading up");
             chk(pin_b, 1'b1, "R7 mode 11 set heading up");
    adv(8);  chk(pin_a, 1'b0, "R10 no action before falling match");
    adv(9);  chk(pin_a, 1'b1, "R7 mode 10 set heading down");
             chk(pin_b, 1'b0, "R7 mode 11 clear heading down");
    adv(12); chk(pin_a, 1'b1, "R10 turn at bottom");
    adv(13); chk(pin_a, 1'b0, "R10 period of 2xTOP edges");
  endtask

  task automatic t_dual_top();
    setup(4'd10, 2'b10, 2'b11, 16'd5, 16'd5, 16'd5);
    reset_dut();
    adv(1);  chk(pin_a, 1'b1, "R9 dual set at bottom");
    adv(6);  chk(pin_a, 1'b1, "R9 dual mode 10 stays high at TOP");
             chk(pin_b, 1'b0, "R9 dual mode 11 stays low at TOP");
    adv(11); chk(pin_a, 1'b1, "R9 dual full duty");
  endtask

  task automatic t_dual_toggle();
    setup(4'd11, 2'b01, 2'b01, 16'd4, 16'd0, 16'd0);
    reset_dut();
    chk(pin_a_en, 1'b1, "R8 A toggle enabled in mode 11");
    chk(pin_b_en, 1'b0, "R8 B disconnected by 01");
    adv(5);  chk(pin_a, 1'b1, "R8 toggle at TOP");
    adv(12); chk(pin_a, 1'b1, "R8 hold over slope");
    adv(13); chk(pin_a, 1'b0, "R8 toggle next TOP");
    cnt_en = 1'b0;
    wave_mode = 4'd10; #1 chk(pin_a_en, 1'b0, "R8 A disconnected in mode 10");
    wave_mode = 4'd8;  #1 chk(pin_a_en, 1'b0, "R8 A disconnected in mode 8");
    wave_mode = 4'd9;  #1 chk(pin_a_en, 1'b1, "R8 A toggle enabled in mode 9");
  endtask

  task automatic t_fast_buffer();
    setup(4'd14, 2'b10, 2'b00, 16'd3, 16'd0, 16'd9);
    reset_dut();
    chk(pin_b_en, 1'b0, "R3 mode 00 disconnects B");
    chk(pin_a_en, 1'b1, "R3 mode 10 connects A");
    adv(12);
    cmp_a = 16'd7;
    adv(15); chk(pin_a, 1'b0, "R11 old compare kept until TOP");
    adv(26); chk(pin_a, 1'b1, "R11 new compare after reload");
    adv(28); chk(pin_a, 1'b0, "R11 new compare acts");
    chk(pin_b, 1'b0, "R3 disconnected B unchanged");
  endtask

  task automatic t_dual_buffer();
    setup(4'd10, 2'b10, 2'b00, 16'd2, 16'd0, 16'd5);
    reset_dut();
    adv(2); cmp_a = 16'd4;
    adv(8); chk(pin_a, 1'b1, "R11 phase correct loads at TOP");
    setup(4'd8, 2'b10, 2'b00, 16'd2, 16'd0, 16'd5);
    reset_dut();
    adv(2); cmp_a = 16'd4;
    adv(8);  chk(pin_a, 1'b0, "R11 phase-frequency keeps old value");
    adv(9);  chk(pin_a, 1'b1, "R11 phase-frequency old match falling");
    adv(15); chk(pin_a, 1'b0, "R11 phase-frequency new value after bottom");
  endtask

  task automatic t_ctc();
    setup(4'd4, 2'b01, 2'b11, 16'd3, 16'd1, 16'd0);
    reset_dut();
    adv(2); chk(pin_b, 1'b1, "R13 mode 11 sets on match");
    adv(4); chk(pin_a, 1'b1, "R13 mode 01 toggles on match");
    cnt_en = 1'b0;
    repeat (5) @(negedge clk);
    chk(pin_a, 1'b1, "R12 pin A held while paused");
    chk(pin_b, 1'b1, "R12 pin B held while paused");
    cnt_en = 1'b1;
    adv(7); chk(pin_a, 1'b1, "R12 count resumes without skip");
    adv(8); chk(pin_a, 1'b0, "R2 CTC period from compare A");
    om_b = 2'b10;
    adv(10); chk(pin_b, 1'b0, "R13 mode 10 clears on match");
  endtask

  task automatic t_fixed_top();
    setup(4'd5, 2'b10, 2'b00, 16'h0080, 16'd0, 16'd0);
    reset_dut();
    adv(129); chk(pin_a, 1'b0, "R2 mode 5 clear at 0x80");
    adv(256); chk(pin_a, 1'b0, "R2 mode 5 low until 0xFF");
    adv(257); chk(pin_a, 1'b1, "R2 mode 5 wraps after 0xFF");
    setup(4'd6, 2'b10, 2'b00, 16'h0080, 16'd0, 16'd0);
    reset_dut();
    adv(257); chk(pin_a, 1'b0, "R2 mode 6 no wrap at 0xFF");
    adv(513); chk(pin_a, 1'b1, "R2 mode 6 wraps after 0x1FF");
  endtask

  task automatic t_plain();
    setup(4'd3, 2'b00, 2'b01, 16'd5, 16'd2, 16'd0);
    reset_dut();
    chk(pin_b_en, 1'b1, "R2 unused code acts as free-running");
    adv(3); chk(pin_b, 1'b1, "R13 toggle in unused code");
    setup(4'd0, 2'b01, 2'b01, 16'd5, 16'd2, 16'd0);
    reset_dut();
    chk(pin_a_en, 1'b1, "R13 toggle connects A");
    adv(6);     chk(pin_a, 1'b1, "R13 first toggle");
    adv(65541); chk(pin_a, 1'b1, "R2 no early wrap");
    adv(65542); chk(pin_a, 1'b0, "R2 wrap after 0xFFFF");
  endtask

  initial begin
    rst_n = 1'b0; cnt_en = 1'b0;
    setup(4'd0, 2'b00, 2'b00, 16'd0, 16'd0, 16'd0);
    t_reset();
    t_fast_polarity();
    t_fast_top();
    t_fast_toggle();
    t_dual_polarity();
    t_dual_top();
    t_dual_toggle();
    t_fast_buffer();
    t_dual_buffer();
    t_ctc();
    t_fixed_top();
    t_plain();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule